// File: doc/BRIEF.md
# Safety-Framed I2C Command Layer

This block is the frame layer of an I2C target. A byte engine below it handles the bus wires and hands it whole received bytes, start, repeated-start and stop events, and requests for bytes to transmit. The block validates each frame and reports whether every byte is to be acknowledged. A write frame is only passed on to the register side once it has been fully validated. A read command is answered with register bytes supplied by the register side.

A frame opens with the device address and direction bit, then repeats the 7-bit address with a 0 in the top bit as a safety copy. Next comes a command byte that selects a register group and fixes the number of data bytes. When checking is enabled, a CRC8 byte closes the frame. A read is a two-phase frame. The command phase carries the addresses, the command byte and the optional CRC. After a repeated start, the read phase carries the read address, the data bytes and a CRC of its own. Any framing or checksum failure sets a sticky error flag, which is cleared when the status group is read.

Top module: `i2c_frame_ctl`

## Requirements
- R1: After reset, ack_valid_o, tx_valid_o and wr_commit_o are 0 and err_flag_o is 0.
- R2: The first byte after a start is {2'b11, addr_low_i, rw}. A byte whose upper seven bits differ is NACKed, and the rest of that frame is ignored without setting the error flag.
- R3: The second byte must equal {1'b0, 2'b11, addr_low_i}. Any other value is NACKed, sets the error flag, and the frame commits nothing.
- R4: The command byte fixes the data length. The write commands are 0x00 (2 bytes), 0x01 (1), 0x02 (3), 0x03 (12) and 0x04 (5). The read commands are 0x08 (1), 0x09 (2) and 0x0A (4). Any other value is NACKed and sets the error flag.
- R5: A write frame is complete after its last data byte when crc_en_i is 0, or after a matching CRC byte when crc_en_i is 1. In the cycle after that byte, wr_commit_o pulses for one cycle with wr_id_o, wr_len_o and wr_data_o, where data byte k sits at bits [8k+7:8k].
- R6: The CRC8 uses polynomial 0x2F (x^8+x^5+x^3+x^2+x+1). It starts at 0x00, is processed MSB first and has no final XOR. It covers both address bytes, the command byte and the data bytes. A mismatching CRC byte is NACKed, sets the error flag and commits nothing.
- R7: When crc_en_i is 0, no CRC byte is expected. Any byte received after a completed write frame is NACKed and sets the error flag.
- R8: After a repeated start and the read address {2'b11, addr_low_i, 1'b1}, each tx_req_i returns the next byte of rd_data_i, with byte k at bits [8k+7:8k]. After the data, it returns the CRC when crc_en_i is 1; the read-phase CRC restarts at the repeated start and covers the read address and the data bytes. Every further request returns 0xFF.
- R9: The error flag stays set until the first data byte of a read of command 0x08 or 0x0A is handed out. A new error in the same cycle as that clear keeps the flag set.
- R10: A stop, start or repeated start before a frame is complete sets the error flag, and nothing is committed.
- R11: ack_valid_o is 1 in the cycle after each rx_valid_i. tx_valid_o is 1 in the cycle after each tx_req_i in the read data phase.
- R12: A read address received directly after a plain start, with no command phase before it, is NACKed and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_low_i | input | 5 | Programmable low address bits |
| crc_en_i | input | 1 | Enables CRC8 checking and generation |
| start_i | input | 1 | Start event pulse |
| rstart_i | input | 1 | Repeated-start event pulse |
| stop_i | input | 1 | Stop event pulse |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_req_i | input | 1 | Engine requests next byte to send |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| rd_id_o | output | 8 | Command byte of the pending read |
| rd_data_i | input | 32 | Read group bytes from the register side |
| wr_commit_o | output | 1 | Validated write frame pulse |
| wr_id_o | output | 8 | Command byte of the committed write |
| wr_len_o | output | 4 | Data byte count of the committed write |
| wr_data_o | output | 96 | Write data bytes |
| err_flag_o | output | 1 | Sticky communication error flag |

## Verification
A wrong frame state shows at the ports on the very next byte. That byte is answered by a NACK where an ACK was due, or the reverse, in the cycle after its strobe. A corrupted running checksum or byte counter stays hidden until the end of the frame. There it appears as a missing or spurious commit pulse, a rejected CRC byte, or a wrong checksum byte on the read side. The tests therefore check each frame byte by byte, as well as at its closing byte.

// File: rtl/i2c_frame_pkg.sv
package i2c_frame_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_CMD,
        ST_WDATA,
        ST_WCRC,
        ST_WDONE,
        ST_RCRC,
        ST_RWAIT,
        ST_RADDR,
        ST_RDATA,
        ST_SKIP
    } frame_st_e;

    localparam logic [1:0] ADDR_FIXED = 2'b11;
    localparam logic [7:0] CRC_POLY   = 8'h2F;

    localparam logic [7:0] CMD_CONF   = 8'h00;
    localparam logic [7:0] CMD_DUTY   = 8'h01;
    localparam logic [7:0] CMD_PWMCFG = 8'h02;
    localparam logic [7:0] CMD_CHDUTY = 8'h03;
    localparam logic [7:0] CMD_WRALL  = 8'h04;
    localparam logic [7:0] CMD_STAT   = 8'h08;
    localparam logic [7:0] CMD_FAULT  = 8'h09;
    localparam logic [7:0] CMD_RDALL  = 8'h0A;

    localparam int LEN_CONF   = 2;
    localparam int LEN_DUTY   = 1;
    localparam int LEN_PWMCFG = 3;
    localparam int LEN_CHDUTY = 12;
    localparam int LEN_WRALL  = 5;
    localparam int LEN_STAT   = 1;
    localparam int LEN_FAULT  = 2;
    localparam int LEN_RDALL  = 4;

endpackage

// File: rtl/i2c_crc8_step.sv
module i2c_crc8_step #(
    parameter logic [7:0] POLY = 8'h2F
) (
    input  logic [7:0] crc_i,
    input  logic [7:0] data_i,
    output logic [7:0] crc_o
);
    logic [7:0] work;

    always_comb begin
        work = crc_i ^ data_i;
        for (int b = 0; b < 8; b++) begin
            work = work[7] ? ({work[6:0], 1'b0} ^ POLY) : {work[6:0], 1'b0};
        end
        crc_o = work;
    end
endmodule

// File: rtl/i2c_id_decode.sv
module i2c_id_decode
    import i2c_frame_pkg::*;
#(
    parameter int LENW = 4
) (
    input  logic [7:0]      id_i,
    output logic            is_wr_o,
    output logic            is_rd_o,
    output logic            clr_err_o,
    output logic [LENW-1:0] len_o
);
    always_comb begin
        is_wr_o   = 1'b0;
        is_rd_o   = 1'b0;
        clr_err_o = 1'b0;
        len_o     = '0;
        case (id_i)
            CMD_CONF:   begin is_wr_o = 1'b1; len_o = LENW'(LEN_CONF);   end
            CMD_DUTY:   begin is_wr_o = 1'b1; len_o = LENW'(LEN_DUTY);   end
            CMD_PWMCFG: begin is_wr_o = 1'b1; len_o = LENW'(LEN_PWMCFG); end
            CMD_CHDUTY: begin is_wr_o = 1'b1; len_o = LENW'(LEN_CHDUTY); end
            CMD_WRALL:  begin is_wr_o = 1'b1; len_o = LENW'(LEN_WRALL);  end
            CMD_STAT:   begin is_rd_o = 1'b1; clr_err_o = 1'b1; len_o = LENW'(LEN_STAT);  end
            CMD_FAULT:  begin is_rd_o = 1'b1; len_o = LENW'(LEN_FAULT);  end
            CMD_RDALL:  begin is_rd_o = 1'b1; clr_err_o = 1'b1; len_o = LENW'(LEN_RDALL);  end
            default:    ;
        endcase
    end
endmodule

// File: rtl/i2c_wr_buffer.sv
module i2c_wr_buffer #(
    parameter int NBYTES = 12,
    parameter int IDXW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [IDXW-1:0]   idx_i,
    input  logic [7:0]        data_i,
    output logic [NBYTES*8-1:0] bytes_o
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [7:0] byte_d, byte_q;

        always_comb begin
            byte_d = byte_q;
            if (clr_i) begin
                byte_d = 8'h00;
            end else if (we_i && idx_i == IDXW'(g)) begin
                byte_d = data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byte_q <= 8'h00;
            else        byte_q <= byte_d;
        end

        assign bytes_o[8*g +: 8] = byte_q;
    end
endmodule

// File: rtl/i2c_frame_ctl.sv
module i2c_frame_ctl
    import i2c_frame_pkg::*;
#(
    parameter int MAX_WR_BYTES = 12,
    parameter int MAX_RD_BYTES = 4,
    parameter int CNTW         = $clog2(MAX_WR_BYTES + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [4:0]                addr_low_i,
    input  logic                      crc_en_i,
    input  logic                      start_i,
    input  logic                      rstart_i,
    input  logic                      stop_i,
    input  logic                      rx_valid_i,
    input  logic [7:0]                rx_data_i,
    output logic                      ack_valid_o,
    output logic                      ack_o,
    input  logic                      tx_req_i,
    output logic                      tx_valid_o,
    output logic [7:0]                tx_data_o,
    output logic [7:0]                rd_id_o,
    input  logic [MAX_RD_BYTES*8-1:0] rd_data_i,
    output logic                      wr_commit_o,
    output logic [7:0]                wr_id_o,
    output logic [CNTW-1:0]           wr_len_o,
    output logic [MAX_WR_BYTES*8-1:0] wr_data_o,
    output logic                      err_flag_o
);
    localparam int WIDX = $clog2(MAX_WR_BYTES);

    typedef struct packed {
        frame_st_e       st;
        logic [7:0]      crc;
        logic [7:0]      id;
        logic [CNTW-1:0] len;
        logic [CNTW-1:0] cnt;
        logic            clr_cmd;
        logic            ack_v;
        logic            ack;
        logic            tx_v;
        logic [7:0]      tx;
        logic            commit;
        logic            err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [6:0] own_addr;
    logic       dec_wr, dec_rd, dec_clr;
    logic [CNTW-1:0] dec_len;
    logic [7:0] crc_rx_next, crc_tx_next, rd_byte;
    logic       buf_we, buf_clr, set_err, clr_err, open_frame;

    assign own_addr = {ADDR_FIXED, addr_low_i};

    i2c_id_decode #(.LENW(CNTW)) u_dec (
        .id_i      (rx_data_i),
        .is_wr_o   (dec_wr),
        .is_rd_o   (dec_rd),
        .clr_err_o (dec_clr),
        .len_o     (dec_len)
    );

    i2c_crc8_step #(.POLY(CRC_POLY)) u_crc_rx (
        .crc_i  (ctl_q.crc),
        .data_i (rx_data_i),
        .crc_o  (crc_rx_next)
    );

    i2c_crc8_step #(.POLY(CRC_POLY)) u_crc_tx (
        .crc_i  (ctl_q.crc),
        .data_i (rd_byte),
        .crc_o  (crc_tx_next)
    );

    i2c_wr_buffer #(.NBYTES(MAX_WR_BYTES), .IDXW(WIDX)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (buf_clr),
        .we_i    (buf_we),
        .idx_i   (ctl_q.cnt[WIDX-1:0]),
        .data_i  (rx_data_i),
        .bytes_o (wr_data_o)
    );

    always_comb begin
        rd_byte = 8'hFF;
        for (int k = 0; k < MAX_RD_BYTES; k++) begin
            if (ctl_q.cnt == CNTW'(k)) rd_byte = rd_data_i[8*k +: 8];
        end
    end

    assign open_frame = ctl_q.st inside {ST_ADDR2, ST_CMD, ST_WDATA, ST_WCRC,
                                         ST_RCRC, ST_RWAIT, ST_RADDR};

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.ack_v  = 1'b0;
        ctl_d.ack    = 1'b0;
        ctl_d.tx_v   = 1'b0;
        ctl_d.commit = 1'b0;
        buf_we       = 1'b0;
        buf_clr      = 1'b0;
        set_err      = 1'b0;
        clr_err      = 1'b0;

        if (start_i || rstart_i) begin
            ctl_d.crc = 8'h00;
            if (rstart_i && ctl_q.st == ST_RWAIT) begin
                ctl_d.st = ST_RADDR;
            end else begin
                set_err  = open_frame;
                buf_clr  = 1'b1;
                ctl_d.st = ST_ADDR1;
            end
        end else if (stop_i) begin
            set_err  = open_frame;
            ctl_d.st = ST_IDLE;
        end else if (rx_valid_i) begin
            ctl_d.ack_v = 1'b1;
            case (ctl_q.st)
                ST_ADDR1: begin
                    if (rx_data_i[7:1] != own_addr) begin
                        ctl_d.st = ST_SKIP;
                    end else if (rx_data_i[0]) begin
                        set_err  = 1'b1;
                        ctl_d.st = ST_SKIP;
                    end else begin
                        ctl_d.ack = 1'b1;
                        ctl_d.crc = crc_rx_next;
                        ctl_d.st  = ST_ADDR2;
                    end
                end
                ST_ADDR2: begin
                    if (rx_data_i == {1'b0, own_addr}) begin
                        ctl_d.ack = 1'b1;
                        ctl_d.crc = crc_rx_next;
                        ctl_d.st  = ST_CMD;
                    end else begin
                        set_err  = 1'b1;
                        ctl_d.st = ST_SKIP;
                    end
                end
                ST_CMD: begin
                    ctl_d.id      = rx_data_i;
                    ctl_d.len     = dec_len;
                    ctl_d.cnt     = '0;
                    ctl_d.clr_cmd = dec_clr;
                    ctl_d.crc     = crc_rx_next;
                    if (dec_wr) begin
                        ctl_d.ack = 1'b1;
                        ctl_d.st  = ST_WDATA;
                    end else if (dec_rd) begin
                        ctl_d.ack = 1'b1;
                        ctl_d.st  = crc_en_i ? ST_RCRC : ST_RWAIT;
                    end else begin
                        set_err  = 1'b1;
                        ctl_d.st = ST_SKIP;
                    end
                end
                ST_WDATA: begin
                    ctl_d.ack = 1'b1;
                    ctl_d.crc = crc_rx_next;
                    buf_we    = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt + 1'b1 == ctl_q.len) begin
                        if (crc_en_i) begin
                            ctl_d.st = ST_WCRC;
                        end else begin
                            ctl_d.commit = 1'b1;
                            ctl_d.st     = ST_WDONE;
                        end
                    end
                end
                ST_WCRC: begin
                    if (rx_data_i == ctl_q.crc) begin
                        ctl_d.ack    = 1'b1;
                        ctl_d.commit = 1'b1;
                        ctl_d.st     = ST_WDONE;
                    end else begin
                        set_err  = 1'b1;
                        ctl_d.st = ST_SKIP;
                    end
                end
                ST_RCRC: begin
                    if (rx_data_i == ctl_q.crc) begin
                        ctl_d.ack = 1'b1;
                        ctl_d.st  = ST_RWAIT;
                    end else begin
                        set_err  = 1'b1;
                        ctl_d.st = ST_SKIP;
                    end
                end
                ST_RADDR: begin
                    if (rx_data_i == {own_addr, 1'b1}) begin
                        ctl_d.ack = 1'b1;
                        ctl_d.crc = crc_rx_next;
                        ctl_d.cnt = '0;
                        ctl_d.st  = ST_RDATA;
                    end else begin
                        set_err  = 1'b1;
                        ctl_d.st = ST_SKIP;
                    end
                end
                ST_WDONE, ST_RWAIT, ST_RDATA: begin
                    set_err  = 1'b1;
                    ctl_d.st = ST_SKIP;
                end
                default: ;
            endcase
        end else if (tx_req_i && ctl_q.st == ST_RDATA) begin
            ctl_d.tx_v = 1'b1;
            if (ctl_q.cnt < ctl_q.len) begin
                ctl_d.tx  = rd_byte;
                ctl_d.crc = crc_tx_next;
                clr_err   = ctl_q.clr_cmd && (ctl_q.cnt == '0);
            end else if (ctl_q.cnt == ctl_q.len && crc_en_i) begin
                ctl_d.tx = ctl_q.crc;
            end else begin
                ctl_d.tx = 8'hFF;
            end
            if (ctl_q.cnt <= ctl_q.len) ctl_d.cnt = ctl_q.cnt + 1'b1;
        end

        ctl_d.err = set_err | (ctl_q.err & ~clr_err);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ack_valid_o = ctl_q.ack_v;
    assign ack_o       = ctl_q.ack;
    assign tx_valid_o  = ctl_q.tx_v;
    assign tx_data_o   = ctl_q.tx;
    assign rd_id_o     = ctl_q.id;
    assign wr_commit_o = ctl_q.commit;
    assign wr_id_o     = ctl_q.id;
    assign wr_len_o    = ctl_q.len;
    assign err_flag_o  = ctl_q.err;

endmodule

// File: rtl/i2c_frame_ctl_chk.sv
module i2c_frame_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic rstart_i,
    input logic stop_i,
    input logic rx_valid_i,
    input logic tx_req_i,
    input logic ack_valid_o,
    input logic ack_o,
    input logic tx_valid_o,
    input logic wr_commit_o,
    input logic err_flag_o
);
    // R11: every byte strobe without a competing bus event gets a decision next cycle
    assert_ack_follows_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !start_i && !rstart_i && !stop_i) |=> ack_valid_o);

    // R11: a transmit byte only appears after a request
    assert_tx_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> $past(tx_req_i));

    // R5: a commit always coincides with an acknowledged closing byte
    assert_commit_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> (ack_valid_o && ack_o));

    // R6: a rejected byte never commits
    assert_nack_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && !ack_o) |-> !wr_commit_o);

    // R9: the error flag only rises because of a byte or bus event
    assert_err_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag_o) |-> $past(rx_valid_i || start_i || rstart_i || stop_i));

    // R5: a commit is a single-cycle pulse
    assert_commit_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |=> !wr_commit_o);
endmodule

bind i2c_frame_ctl i2c_frame_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rstart_i    (rstart_i),
    .stop_i      (stop_i),
    .rx_valid_i  (rx_valid_i),
    .tx_req_i    (tx_req_i),
    .ack_valid_o (ack_valid_o),
    .ack_o       (ack_o),
    .tx_valid_o  (tx_valid_o),
    .wr_commit_o (wr_commit_o),
    .err_flag_o  (err_flag_o)
);

// File: tb/i2c_frame_ctl_tb.sv
module i2c_frame_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr_low = 5'h0A;
    logic        crc_en = 1'b0;
    logic        start_p = 1'b0, rstart_p = 1'b0, stop_p = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_req = 1'b0;
    logic [31:0] rd_data = 32'h0;
    logic        ack_valid, ack, tx_valid, commit, err;
    logic [7:0]  tx_data, rd_id, wr_id;
    logic [3:0]  wr_len;
    logic [95:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] AW = 8'hD4;
    localparam logic [7:0] A2 = 8'h6A;
    localparam logic [7:0] AR = 8'hD5;

    always #5 clk = ~clk;

    i2c_frame_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .addr_low_i(addr_low), .crc_en_i(crc_en),
        .start_i(start_p), .rstart_i(rstart_p), .stop_i(stop_p),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .ack_valid_o(ack_valid), .ack_o(ack),
        .tx_req_i(tx_req), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
        .rd_id_o(rd_id), .rd_data_i(rd_data),
        .wr_commit_o(commit), .wr_id_o(wr_id), .wr_len_o(wr_len),
        .wr_data_o(wr_data), .err_flag_o(err)
    );

    function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ b[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h2F;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, output logic a, output logic c);
        @(negedge clk); rx_data = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        a = ack_valid & ack;
        c = commit;
    endtask

    task automatic ev_start();
        @(negedge clk); start_p = 1'b1; @(negedge clk); start_p = 1'b0;
    endtask
    task automatic ev_rstart();
        @(negedge clk); rstart_p = 1'b1; @(negedge clk); rstart_p = 1'b0;
    endtask
    task automatic ev_stop();
        @(negedge clk); stop_p = 1'b1; @(negedge clk); stop_p = 1'b0;
    endtask
    task automatic pull(output logic v, output logic [7:0] d);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        v = tx_valid; d = tx_data;
    endtask

    // clears the sticky flag through a plain status read
    task automatic clear_err();
        logic a, c, v; logic [7:0] d;
        logic keep = crc_en;
        crc_en = 1'b0;
        ev_start(); send(AW, a, c); send(A2, a, c); send(8'h08, a, c);
        ev_rstart(); send(AR, a, c); pull(v, d); ev_stop();
        crc_en = keep;
    endtask

    task automatic t_reset();
        check("R1 ack_valid", ack_valid, 0);
        check("R1 tx_valid", tx_valid, 0);
        check("R1 commit", commit, 0);
        check("R1 err", err, 0);
    endtask

    task automatic t_write_short();
        logic a, c;
        crc_en = 1'b0;
        ev_start();
        send(AW, a, c); check("R2 addr ack", a, 1);
        check("R11 ack_valid", ack_valid, 1);
        send(A2, a, c); check("R3 repeat ack", a, 1);
        send(8'h01, a, c); check("R4 id ack", a, 1);
        send(8'h5C, a, c); check("R5 commit", c, 1);
        check("R5 wr_id", wr_id, 8'h01);
        check("R5 wr_len", wr_len, 1);
        check("R5 wr_data", wr_data[7:0], 8'h5C);
        ev_stop();
        check("R5 no err", err, 0);
    endtask

    task automatic t_id_length();
        logic a, c;
        crc_en = 1'b0;
        ev_start(); send(AW, a, c); send(A2, a, c); send(8'h02, a, c);
        send(8'h11, a, c); check("R4 no early commit b1", c, 0);
        send(8'h22, a, c); check("R4 no early commit b2", c, 0);
        send(8'h33, a, c); check("R4 commit at 3", c, 1);
        check("R4 len 3", wr_len, 3);
        check("R5 data 3", wr_data[23:0], 24'h332211);
        ev_stop();
    endtask

    task automatic t_write_crc();
        logic a, c; logic [7:0] cr; logic [95:0] exp;
        crc_en = 1'b1;
        cr = crc_add(crc_add(crc_add(8'h00, AW), A2), 8'h03);
        exp = '0;
        ev_start(); send(AW, a, c); send(A2, a, c); send(8'h03, a, c);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] b = 8'h10 + 8'(i * 7);
            exp[8*i +: 8] = b;
            cr = crc_add(cr, b);
            send(b, a, c);
            if (i == 11) check("R6 no commit before crc", c, 0);
        end
        send(cr, a, c);
        check("R6 crc ack", a, 1);
        check("R5 commit long", c, 1);
        check("R5 data long", wr_data, exp);
        check("R5 len long", wr_len, 12);
        ev_stop();
    endtask

    task automatic t_bad_crc();
        logic a, c; logic [7:0] cr;
        crc_en = 1'b1;
        cr = crc_add(crc_add(crc_add(crc_add(8'h00, AW), A2), 8'h01), 8'h77);
        ev_start(); send(AW, a, c); send(A2, a, c); send(8'h01, a, c); send(8'h77, a, c);
        send(cr ^ 8'h01, a, c);
        check("R6 bad crc nack", a, 0);
        check("R6 bad crc no commit", c, 0);
        check("R6 bad crc err", err, 1);
        ev_stop();
    endtask

    task automatic t_status_read();
        logic a, c, v; logic [7:0] d, cr;
        crc_en = 1'b1;
        rd_data = 32'h0000_00E7;
        cr = crc_add(crc_add(crc_add(8'h00, AW), A2), 8'h08);
        ev_start(); send(AW, a, c); send(A2, a, c); send(8'h08, a, c);
        send(cr, a, c); check("R6 read cmd crc ack", a, 1);
        check("R9 still set", err, 1);
        ev_rstart(); send(AR, a, c); check("R8 read addr ack", a, 1);
        pull(v, d);
        check("R8 status byte", {v, d}, {1'b1, 8'hE7});
        check("R9 cleared", err, 0);
        pull(v, d);
        check("R8 status crc", d, crc_add(crc_add(8'h00, AR), 8'hE7));
        ev_stop();
    endtask

    task automatic t_wrong_addr();
        logic a, c;
        ev_start(); send(8'h12, a, c); check("R2 foreign nack", a, 0);
        send(A2, a, c); check("R2 rest ignored", a, 0);
        ev_stop();
        check("R2 no err", err, 0);
    endtask

    task automatic t_addr2_bad();
        logic a, c;
        crc_en = 1'b0;
        ev_start(); send(AW, a, c); send(8'h6B, a, c);
        check("R3 mismatch nack", a, 0);
        check("R3 mismatch err", err, 1);
        send(8'h01, a, c); send(8'h44, a, c);
        check("R3 no commit", c, 0);
        ev_stop(); clear_err();
    endtask

    task automatic t_unknown_id();
        logic a, c;
        crc_en = 1'b0;
        ev_start(); send(AW, a, c); send(A2, a, c); send(8'h05, a, c);
        check("R4 unknown nack", a, 0);
        check("R4 unknown err", err, 1);
        ev_stop(); clear_err();
        check("R9 cleared by status read", err, 0);
    endtask

    task automatic t_extra_byte();
        logic a, c;
        crc_en = 1'b0;
        ev_start(); send(AW, a, c); send(A2, a, c); send(8'h01, a, c);
        send(8'hAA, a, c); check("R7 commit no crc", c, 1);
        send(8'hBB, a, c);
        check("R7 extra nack", a, 0);
        check("R7 extra err", err, 1);
        ev_stop(); clear_err();
    endtask

    task automatic t_stop_mid();
        logic a, c;
        crc_en = 1'b0;
        ev_start(); send(AW, a, c); send(A2, a, c); send(8'h00, a, c); send(8'h9E, a, c);
        check("R10 no commit partial", c, 0);
        ev_stop();
        check("R10 stop err", err, 1);
        clear_err();
    endtask

    task automatic t_read_all();
        logic a, c, v; logic [7:0] d, cr, rc;
        crc_en = 1'b1;
        rd_data = 32'hA1B2_C3D4;
        cr = crc_add(crc_add(crc_add(8'h00, AW), A2), 8'h0A);
        ev_start(); send(AW, a, c); send(A2, a, c); send(8'h0A, a, c); send(cr, a, c);
        check("R8 rd_id", rd_id, 8'h0A);
        ev_rstart(); send(AR, a, c);
        rc = crc_add(8'h00, AR);
        for (int k = 0; k < 4; k++) begin
            pull(v, d);
            check("R8 read byte", d, rd_data[8*k +: 8]);
            rc = crc_add(rc, rd_data[8*k +: 8]);
        end
        pull(v, d); check("R8 read crc", d, rc);
        pull(v, d); check("R8 pad", {v, d}, {1'b1, 8'hFF});
        ev_stop();
    endtask

    task automatic t_read_no_cmd();
        logic a, c;
        ev_start(); send(AR, a, c);
        check("R12 nack", a, 0);
        check("R12 err", err, 1);
        ev_stop(); clear_err();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write_short();
        t_id_length();
        t_write_crc();
        t_bad_crc();
        t_status_read();
        t_wrong_addr();
        t_addr2_bad();
        t_unknown_id();
        t_extra_byte();
        t_stop_mid();
        t_read_all();
        t_read_no_cmd();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule